// File: doc/BRIEF.md
# Program-Driven Five-Port Tile Switch

This block is the routing switch of one tile in a two-dimensional mesh. It connects five word-wide ports: the tile's own processor (P) and the four neighbours (N, E, S, W). No header is read from the data. A small instruction memory, filled before the switch starts, tells the switch which input feeds each output at every step. A program counter walks through that memory. One instruction can name several transfers, and all of them happen in the same cycle.

Every port uses a valid/ready handshake. An instruction completes only when every input it reads has a word and every output it writes can take one. Otherwise the whole instruction waits and nothing moves. Each input has a two-word buffer, so a neighbour can keep sending for a short time while the switch waits. Each output is registered. The instruction memory is written through a separate load port while the switch is held in reset. Once reset is released, the switch runs its program from address 0. A jump field in each instruction lets a streaming loop run for as long as needed.

Top module: `static_xbar_switch`

## Requirements
- R1: While reset is asserted, and for two clock edges after it is released, every out_valid and every in_ready is 0. The program counter restarts at address 0.
- R2: When load_en is 1 on a clock edge, load_data is written to instruction address load_addr. Loading works while rst_n is low.
- R3: Instruction bits [3k+2:3k] choose the source for output k, with ports numbered P=0, N=1, E=2, S=3, W=4. The codes are 0 for no transfer, 1 for P, 2 for N, 3 for E, 4 for S and 5 for W; codes 6 and 7 also mean no transfer. All transfers named in one instruction take place in the same cycle. Several outputs may choose the same input, in which case each of them receives a copy of the word.
- R4: An instruction completes only if every input it names holds a word and every output it names is either empty or has out_ready high. If either condition fails, no input buffer is popped, no output is loaded and the program counter does not move.
- R5: Bit 15 of an instruction is the jump flag and bits [16+AW-1:16] hold the target address. When an instruction completes with the flag set, the program counter takes the target. When it completes with the flag clear, the counter increments and wraps from the last address to 0.
- R6: Each input holds at most two words. in_ready is 1 exactly when the input holds fewer than two words and the switch is out of reset.
- R7: Words that travel from a given input to a given output arrive in the order they were sent. No word is lost and no word is delivered twice.
- R8: While an output is valid and its out_ready is low, out_valid stays 1 and out_data does not change.
- R9: An instruction that names no transfer completes on the next clock edge, whatever the state of the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_en | input | 1 | Instruction memory write strobe |
| load_addr | input | AW | Instruction memory write address |
| load_data | input | 16+AW | Instruction word to write |
| in_valid | input | 5 | Per-input word valid, indexed P,N,E,S,W = 0..4 |
| in_ready | output | 5 | Per-input buffer has room |
| in_data | input | 5 x W | Per-input data words |
| out_valid | output | 5 | Per-output word valid |
| out_ready | input | 5 | Per-output sink accepts |
| out_data | output | 5 x W | Per-output data words |

## Verification
If the program counter is wrong, the next transfer lands on the wrong output, or carries a word from the wrong input, one or two cycles after the faulty step. A buffer count that is off shows up at once on in_ready, and soon after as a lost or repeated word in the output stream. A partial step, where one transfer of an instruction moves while another waits, shows up on the very next cycle: an output becomes valid while the matching input word is still buffered. A cycle-level reference model catches each of these on the first cycle it appears at the ports.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NP      = 5;
  localparam int SELW    = 3;
  localparam int JMP_BIT = NP * SELW;
  localparam int TGT_LSB = JMP_BIT + 1;

  typedef enum logic [SELW-1:0] {
    SRC_NONE = 3'd0,
    SRC_P    = 3'd1,
    SRC_N    = 3'd2,
    SRC_E    = 3'd3,
    SRC_S    = 3'd4,
    SRC_W    = 3'd5
  } src_code_e;
endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/xbar_in_fifo.sv
module xbar_in_fifo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         has_word,
  output logic         has_room,
  output logic [W-1:0] head
);
  logic [1:0]   cnt_q, cnt_d;
  logic [W-1:0] slot0_q, slot0_d, slot1_q, slot1_d;
  logic         slot0_en, slot1_en;

  always_comb begin
    cnt_d    = cnt_q;
    slot0_d  = slot0_q;
    slot1_d  = slot1_q;
    slot0_en = 1'b0;
    slot1_en = 1'b0;
    unique case ({push, pop})
      2'b11: begin
        slot0_d  = push_data;
        slot0_en = 1'b1;
      end
      2'b01: begin
        slot0_d  = slot1_q;
        slot0_en = 1'b1;
        cnt_d    = cnt_q - 2'd1;
      end
      2'b10: begin
        if (cnt_q == 2'd0) begin
          slot0_d  = push_data;
          slot0_en = 1'b1;
        end else begin
          slot1_d  = push_data;
          slot1_en = 1'b1;
        end
        cnt_d = cnt_q + 2'd1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (slot0_en) slot0_q <= slot0_d;
    if (slot1_en) slot1_q <= slot1_d;
  end

  assign has_word = (cnt_q != 2'd0);
  assign has_room = rst_n && (cnt_q != 2'd2);
  assign head     = slot0_q;

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != 2'd3);
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != 2'd0);
endmodule

// File: rtl/xbar_out_reg.sv
module xbar_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         sink_ready,
  output logic         can_take,
  output logic         valid,
  output logic [W-1:0] data
);
  logic valid_d;

  always_comb begin
    valid_d = valid;
    if (load)            valid_d = 1'b1;
    else if (sink_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) data <= load_data;
  end

  assign can_take = !valid || sink_ready;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !sink_ready) |=> (valid && $stable(data)));
  p_load_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid || sink_ready));
endmodule

// File: rtl/xbar_step_ctrl.sv
module xbar_step_ctrl
  import xbar_pkg::*;
#(
  parameter int AW = 4,
  parameter int IW = TGT_LSB + AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [AW-1:0]            load_addr,
  input  logic [IW-1:0]            load_data,
  input  logic [NP-1:0]            src_avail,
  input  logic [NP-1:0]            dst_free,
  output logic                     fire,
  output logic [NP-1:0]            out_load,
  output logic [NP-1:0]            src_pop,
  output logic [NP-1:0][SELW-1:0]  src_idx
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] imem [DEPTH];
  logic [AW-1:0] pc_q, pc_d;
  logic [IW-1:0] instr;
  logic [NP-1:0] used, ok;

  always_ff @(posedge clk) begin
    if (load_en) imem[load_addr] <= load_data;
  end

  assign instr = imem[pc_q];

  for (genvar o = 0; o < NP; o++) begin : g_dec
    logic [SELW-1:0] code;
    assign code       = instr[o*SELW +: SELW];
    assign used[o]    = (code >= SRC_P) && (code <= SRC_W);
    assign src_idx[o] = used[o] ? (code - 3'd1) : 3'd0;
    assign ok[o]      = !used[o] || (src_avail[src_idx[o]] && dst_free[o]);
    assign out_load[o] = fire && used[o];
  end

  assign fire = rst_n && (&ok);

  always_comb begin
    src_pop = '0;
    for (int o = 0; o < NP; o++) begin
      if (out_load[o]) src_pop[src_idx[o]] = 1'b1;
    end
  end

  always_comb begin
    pc_d = pc_q;
    if (fire) begin
      if (instr[JMP_BIT]) pc_d = instr[TGT_LSB +: AW];
      else                pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  p_pc_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> pc_q == $past(pc_q));
  p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && instr[JMP_BIT]) |=> pc_q == $past(instr[TGT_LSB +: AW]));
endmodule

// File: rtl/static_xbar_switch.sv
module static_xbar_switch
  import xbar_pkg::*;
#(
  parameter  int W  = 32,
  parameter  int AW = 4,
  localparam int IW = TGT_LSB + AW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [AW-1:0]         load_addr,
  input  logic [IW-1:0]         load_data,
  input  logic [NP-1:0]         in_valid,
  output logic [NP-1:0]         in_ready,
  input  logic [NP-1:0][W-1:0]  in_data,
  output logic [NP-1:0]         out_valid,
  input  logic [NP-1:0]         out_ready,
  output logic [NP-1:0][W-1:0]  out_data
);
  logic                    rst_int_n;
  logic                    fire;
  logic [NP-1:0]           src_avail, dst_free, out_load, src_pop;
  logic [NP-1:0][SELW-1:0] src_idx;
  logic [NP-1:0][W-1:0]    head;

  xbar_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  xbar_step_ctrl #(.AW(AW), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en   (load_en),
    .load_addr (load_addr),
    .load_data (load_data),
    .src_avail (src_avail),
    .dst_free  (dst_free),
    .fire      (fire),
    .out_load  (out_load),
    .src_pop   (src_pop),
    .src_idx   (src_idx)
  );

  for (genvar i = 0; i < NP; i++) begin : g_in
    xbar_in_fifo #(.W(W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .push      (in_valid[i] && in_ready[i]),
      .push_data (in_data[i]),
      .pop       (src_pop[i]),
      .has_word  (src_avail[i]),
      .has_room  (in_ready[i]),
      .head      (head[i])
    );
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    xbar_out_reg #(.W(W)) u_oreg (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .load       (out_load[o]),
      .load_data  (head[src_idx[o]]),
      .sink_ready (out_ready[o]),
      .can_take   (dst_free[o]),
      .valid      (out_valid[o]),
      .data       (out_data[o])
    );
  end

  // R4: a completing step pops exactly the inputs that feed a loaded output
  p_step_atomic_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (src_pop != '0) |-> (fire && out_load != '0));
endmodule

// File: tb/static_xbar_switch_tb.sv
module static_xbar_switch_tb_top;
  localparam int W  = 32;
  localparam int AW = 4;
  localparam int IW = 16 + AW;
  localparam int NP = 5;
  localparam int DEPTH = 1 << AW;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 load_en;
  logic [AW-1:0]        load_addr;
  logic [IW-1:0]        load_data;
  logic [NP-1:0]        in_valid, in_ready, out_valid, out_ready;
  logic [NP-1:0][W-1:0] in_data, out_data;

  always #2 clk = ~clk;

  static_xbar_switch #(.W(W), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [IW-1:0] prog [DEPTH];
  logic [W-1:0]  mq [NP][$];
  bit            mov [NP];
  logic [W-1:0]  mdat [NP];
  int            mpc;

  function automatic logic [IW-1:0] mk(int p, int n, int e, int s, int w,
                                       bit j, int t);
    logic [IW-1:0] v;
    v = '0;
    v[2:0] = p[2:0]; v[5:3] = n[2:0]; v[8:6] = e[2:0];
    v[11:9] = s[2:0]; v[14:12] = w[2:0];
    v[15] = j; v[16 +: AW] = t[AW-1:0];
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step_model();
    int  code, src;
    bit  fire;
    bit  pop [NP];
    bit  rdy [NP];
    for (int i = 0; i < NP; i++) begin
      rdy[i] = (mq[i].size() < 2);
      pop[i] = 0;
    end
    fire = 1;
    for (int o = 0; o < NP; o++) begin
      code = (prog[mpc] >> (3 * o)) & 7;
      if (code >= 1 && code <= 5) begin
        src = code - 1;
        if (mq[src].size() == 0 || (mov[o] && !out_ready[o])) fire = 0;
      end
    end
    for (int o = 0; o < NP; o++) begin
      code = (prog[mpc] >> (3 * o)) & 7;
      if (fire && code >= 1 && code <= 5) begin
        src = code - 1;
        mov[o] = 1; mdat[o] = mq[src][0]; pop[src] = 1;
      end else if (out_ready[o]) begin
        mov[o] = 0;
      end
    end
    for (int i = 0; i < NP; i++) begin
      if (pop[i]) void'(mq[i].pop_front());
      if (in_valid[i] && rdy[i]) mq[i].push_back(in_data[i]);
    end
    if (fire) begin
      if (prog[mpc][15]) mpc = int'(prog[mpc][16 +: AW]);
      else               mpc = (mpc + 1) % DEPTH;
    end
  endtask

  task automatic compare();
    for (int i = 0; i < NP; i++) begin
      chk(in_ready[i] == (mq[i].size() < 2), "R6 in_ready",
          W'(in_ready[i]), W'(mq[i].size() < 2));
      // out_valid tracks R4 (all-or-nothing step), R8 hold, R9 empty steps
      chk(out_valid[i] == mov[i], "R4 R8 R9 out_valid",
          W'(out_valid[i]), W'(mov[i]));
      // out_data tracks R3 routing and fan-out, R5 program order, R7 ordering
      if (mov[i])
        chk(out_data[i] == mdat[i], "R3 R5 R7 out_data", out_data[i], mdat[i]);
    end
  endtask

  task automatic run_cycles(int n, int vpct, int rpct);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      for (int i = 0; i < NP; i++) begin
        in_valid[i]  = ($urandom_range(99) < vpct);
        in_data[i]   = $urandom;
        out_ready[i] = ($urandom_range(99) < rpct);
      end
      #1;
      compare();
      step_model();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) prog[a] = mk(0, 0, 0, 0, 0, 1'b1, 0);
    prog[0] = mk(0, 0, 1, 2, 0, 1'b0, 0);   // P->E, N->S
    prog[1] = mk(5, 4, 0, 0, 0, 1'b0, 0);   // W->P, S->N
    prog[2] = mk(0, 0, 2, 0, 2, 1'b0, 0);   // N fans out to E and W
    prog[3] = mk(0, 0, 0, 0, 0, 1'b0, 0);   // no transfer (R9)
    prog[4] = mk(2, 3, 4, 5, 1, 1'b0, 0);   // all five rotate
    prog[5] = mk(0, 7, 0, 6, 0, 1'b1, 0);   // codes 6/7 idle, jump to 0
    for (int i = 0; i < NP; i++) begin mov[i] = 0; mdat[i] = '0; end
    mpc = 0;

    rst_n = 1'b0; load_en = 1'b0; load_addr = '0; load_data = '0;
    in_valid = '0; in_data = '0; out_ready = '0;
    // R2: program loaded while reset is held
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = AW'(a); load_data = prog[a];
    end
    @(negedge clk);
    load_en = 1'b0;
    #1;
    chk(out_valid == '0, "R1 out_valid in reset", W'(out_valid), '0);
    chk(in_ready == '0, "R1 in_ready in reset", W'(in_ready), '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == '0, "R1 in_ready before sync release", W'(in_ready), '0);
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == '1, "R1 in_ready after release", W'(in_ready), '1);
    chk(out_valid == '0, "R1 out_valid after release", W'(out_valid), '0);

    run_cycles(1500, 60, 70);
    run_cycles(300, 70, 0);    // sinks stalled: R4, R6, R8
    run_cycles(600, 100, 100); // full streaming
    run_cycles(800, 30, 50);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule